// File: doc/BRIEF.md
# Slow Serial Control-Register Slave

This block is the control-register port of a sensor front end. It is reached over a slow serial link with an active-low select. The host always acts as master. Every 8-bit word on the link is tagged by its top bit. A command word names a register and chooses read or write. The data words that follow it either carry 7-bit payloads into that register, or clock the register's value back out to the host.

The block holds the operating-mode, interrupt-enable, heating, navigation, click and movement-threshold settings, plus a status register and a three-byte navigation packet that both clear on read. Click and movement events arrive as single-cycle strobes from logic outside the block. Those strobes set status bits and load the navigation packet. An active-low interrupt line tells the host that an enabled status bit is set. The serial inputs are resynchronised into the system clock, so no logic runs on the serial clock.

Top module: `slow_spi_ctrl_regs`

## Requirements
- R1: Words are 8 bits and travel MSB first. The serial clock idles high. Input bits are taken on its rising edge and the reply bit changes on its falling edge. The reply to a command appears during the data word that follows it.
- R2: A word with b7=1 is a command: b6=1 selects read and b6=0 selects write, b5..b2 give the address, and b1..b0 are ignored. A word with b7=0 is a data word.
- R3: After a write command to address 1 (mode), 2 (enable), 3 (heat), 4 (navigation settings), 5 (click settings) or 6 (movement threshold), each data word stores its b6..b0 in that register. A read of any of these addresses returns {0, value}.
- R4: After reset, mode reads 0x04, navigation settings read 0x20, click settings read 0x2D, the other settings and status read 0x00, and irq_n is high.
- R5: Writes to address 0 (status), to address 8 (navigation packet) and to reserved addresses change nothing.
- R6: A mode write whose b6 (acquisition) is set together with b5 or b4 (navigation or click) is dropped, and the previous mode stays.
- R7: Status has b7 for click, b6 for movement and b3 for read error. Reading address 0 returns the bits and clears them.
- R8: irq_n is low exactly when (status b7 and enable b6), (status b6 and enable b5) or (status b3 and enable b2) holds. A status read therefore releases it.
- R9: A read of address 8 returns three bytes on successive data words. The first is the flags byte {Y overflow, X overflow, Y negative, X negative, 1, 0, click, 0}, the second is absolute X and the third is absolute Y. The read clears all three.
- R10: A status read does not clear the click bit (b1) of the navigation flags byte.
- R11: A movement strobe sets status b6 when its absolute X or absolute Y is greater than twice the movement threshold.
- R12: A read of an unmapped address (7 or 9..15) returns 0x00 and sets status b3.
- R13: Word framing is reset only by rst. A transfer whose clock count is not a multiple of 8 shifts all later word boundaries, and select going high does not realign them.
- R14: Once the bytes of a read are exhausted, further data words return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst | input | 1 | Asynchronous active-high reset; the only way to realign framing |
| sck | input | 1 | Serial clock from the host, idle high |
| ss_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial reply data |
| miso_oe | output | 1 | High while the block is selected |
| irq_n | output | 1 | Active-low interrupt |
| click_evt | input | 1 | Single-cycle click strobe |
| mov_valid | input | 1 | Single-cycle movement strobe |
| mov_x_abs | input | 8 | Absolute X movement |
| mov_y_abs | input | 8 | Absolute Y movement |
| mov_x_neg | input | 1 | X movement is negative |
| mov_y_neg | input | 1 | Y movement is negative |
| mov_x_ovf | input | 1 | X movement counter overflowed |
| mov_y_ovf | input | 1 | Y movement counter overflowed |

## Verification
The bench builds the block with the default two-stage input synchroniser and drives the serial clock at twelve system cycles per bit, which leaves a margin of several cycles on both edges. That small link lets it sweep all sixteen mode codes, a strided range of values through every writable register, and a grid of movement sizes set against thresholds that include zero and the maximum. These sweeps cover the greater-than boundary at exactly twice the threshold. It also forces a three-clock partial transfer to show that the framing stays shifted until rst.

// File: rtl/slow_spi_ctrl_regs.sv
module slow_spi_ctrl_regs #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck,
  input  logic       ss_n,
  input  logic       mosi,
  output logic       miso,
  output logic       miso_oe,
  output logic       irq_n,
  input  logic       click_evt,
  input  logic       mov_valid,
  input  logic [7:0] mov_x_abs,
  input  logic [7:0] mov_y_abs,
  input  logic       mov_x_neg,
  input  logic       mov_y_neg,
  input  logic       mov_x_ovf,
  input  logic       mov_y_ovf
);
  localparam int         WORD_W     = 8;
  localparam int         CNT_W      = $clog2(WORD_W);
  localparam logic [3:0] A_STATUS   = 4'd0;
  localparam logic [3:0] A_MODE     = 4'd1;
  localparam logic [3:0] A_ENABLE   = 4'd2;
  localparam logic [3:0] A_HEAT     = 4'd3;
  localparam logic [3:0] A_NAVSET   = 4'd4;
  localparam logic [3:0] A_CLKSET   = 4'd5;
  localparam logic [3:0] A_MOVTHR   = 4'd6;
  localparam logic [3:0] A_NAVPKT   = 4'd8;
  localparam logic [6:0] MODE_RST   = 7'h04;
  localparam logic [6:0] NAVSET_RST = 7'h20;
  localparam logic [6:0] CLKSET_RST = 7'h2D;

  logic [SYNC_STAGES-1:0] sck_q, mosi_q, ss_q;
  logic sck_d;

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      sck_q  <= '1;
      ss_q   <= '1;
      mosi_q <= '0;
      sck_d  <= 1'b1;
    end else begin
      sck_q  <= {sck_q[SYNC_STAGES-2:0], sck};
      ss_q   <= {ss_q[SYNC_STAGES-2:0], ss_n};
      mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
      sck_d  <= sck_q[SYNC_STAGES-1];
    end

  wire sel    = ~ss_q[SYNC_STAGES-1];
  wire sck_s  = sck_q[SYNC_STAGES-1];
  wire mosi_s = mosi_q[SYNC_STAGES-1];
  wire rise   = sel & sck_s & ~sck_d;
  wire fall   = sel & ~sck_s & sck_d;

  logic [CNT_W-1:0] bit_cnt;
  logic [6:0]       rx_sh;
  logic [7:0]       tx_sh, tx_next;
  logic             cmd_ok, cmd_rd;
  logic [3:0]       cmd_addr;
  logic [1:0]       idx;

  wire       word_done = rise & (bit_cnt == CNT_W'(WORD_W - 1));
  wire       is_cmd    = word_done & rx_sh[6];
  wire       is_data   = word_done & ~rx_sh[6];
  wire [6:0] payload   = {rx_sh[5:0], mosi_s};
  wire [3:0] w_addr    = rx_sh[4:1];
  wire       rd_cmd    = is_cmd & rx_sh[5];
  wire       wr_en     = is_data & cmd_ok & ~cmd_rd;
  wire       known     = (w_addr <= A_MOVTHR) | (w_addr == A_NAVPKT);
  wire       rd_status = rd_cmd & (w_addr == A_STATUS);
  wire       rd_nav    = rd_cmd & (w_addr == A_NAVPKT);
  wire       rd_bad    = rd_cmd & ~known;
  wire       mode_ok   = ~(payload[6] & (payload[5] | payload[4]));

  logic [6:0] mode_r, en_r, heat_r, navset_r, clkset_r, movthr_r;
  logic       st_click, st_mov, st_rderr;
  logic       n_yovf, n_xovf, n_yneg, n_xneg, n_click;
  logic [7:0] nav_x, nav_y, burst_x, burst_y;

  wire mov_hit = mov_valid & ((mov_x_abs > {movthr_r, 1'b0}) | (mov_y_abs > {movthr_r, 1'b0}));
  wire [7:0] status_byte = {st_click, st_mov, 2'b00, st_rderr, 3'b000};
  wire [7:0] nav_flags   = {n_yovf, n_xovf, n_yneg, n_xneg, 1'b1, 1'b0, n_click, 1'b0};

  logic [7:0] rd_value;
  always_comb
    case (w_addr)
      A_STATUS: rd_value = status_byte;
      A_MODE:   rd_value = {1'b0, mode_r};
      A_ENABLE: rd_value = {1'b0, en_r};
      A_HEAT:   rd_value = {1'b0, heat_r};
      A_NAVSET: rd_value = {1'b0, navset_r};
      A_CLKSET: rd_value = {1'b0, clkset_r};
      A_MOVTHR: rd_value = {1'b0, movthr_r};
      A_NAVPKT: rd_value = nav_flags;
      default:  rd_value = 8'h00;
    endcase

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      tx_next  <= '0;
      cmd_ok   <= 1'b0;
      cmd_rd   <= 1'b0;
      cmd_addr <= '0;
      idx      <= '0;
    end else begin
      if (rise) begin
        bit_cnt <= bit_cnt + 1'b1;
        rx_sh   <= payload;
      end
      if (fall) tx_sh <= (bit_cnt == '0) ? tx_next : {tx_sh[6:0], 1'b0};
      if (is_cmd) begin
        cmd_ok   <= 1'b1;
        cmd_rd   <= rx_sh[5];
        cmd_addr <= w_addr;
        idx      <= 2'd1;
        tx_next  <= rx_sh[5] ? rd_value : 8'h00;
      end else if (is_data) begin
        if (cmd_ok && cmd_rd && cmd_addr == A_NAVPKT && idx == 2'd1) tx_next <= burst_x;
        else if (cmd_ok && cmd_rd && cmd_addr == A_NAVPKT && idx == 2'd2) tx_next <= burst_y;
        else tx_next <= 8'h00;
        if (idx != 2'd3) idx <= idx + 1'b1;
      end
    end

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      mode_r   <= MODE_RST;
      en_r     <= '0;
      heat_r   <= '0;
      navset_r <= NAVSET_RST;
      clkset_r <= CLKSET_RST;
      movthr_r <= '0;
    end else if (wr_en) begin
      case (cmd_addr)
        A_MODE:   if (mode_ok) mode_r <= payload;
        A_ENABLE: en_r     <= payload;
        A_HEAT:   heat_r   <= payload;
        A_NAVSET: navset_r <= payload;
        A_CLKSET: clkset_r <= payload;
        A_MOVTHR: movthr_r <= payload;
        default:  ;
      endcase
    end

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      st_click <= 1'b0;
      st_mov   <= 1'b0;
      st_rderr <= 1'b0;
      n_click  <= 1'b0;
      n_xovf   <= 1'b0;
      n_yovf   <= 1'b0;
      n_xneg   <= 1'b0;
      n_yneg   <= 1'b0;
      nav_x    <= '0;
      nav_y    <= '0;
      burst_x  <= '0;
      burst_y  <= '0;
    end else begin
      st_click <= click_evt | (st_click & ~rd_status);
      st_mov   <= mov_hit   | (st_mov   & ~rd_status);
      st_rderr <= rd_bad    | (st_rderr & ~rd_status);
      n_click  <= click_evt | (n_click  & ~rd_nav);
      if (rd_nav) begin
        burst_x <= nav_x;
        burst_y <= nav_y;
      end
      if (mov_valid) begin
        nav_x  <= mov_x_abs;
        nav_y  <= mov_y_abs;
        n_xneg <= mov_x_neg;
        n_yneg <= mov_y_neg;
        n_xovf <= mov_x_ovf | (n_xovf & ~rd_nav);
        n_yovf <= mov_y_ovf | (n_yovf & ~rd_nav);
      end else if (rd_nav) begin
        nav_x  <= '0;
        nav_y  <= '0;
        n_xneg <= 1'b0;
        n_yneg <= 1'b0;
        n_xovf <= 1'b0;
        n_yovf <= 1'b0;
      end
    end

  assign miso    = tx_sh[7];
  assign miso_oe = sel;
  assign irq_n   = ~((st_click & en_r[6]) | (st_mov & en_r[5]) | (st_rderr & en_r[2]));

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst) !(mode_r[6] && (mode_r[5] || mode_r[4]))); // R6
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst) !(wr_en && cmd_addr == A_MODE) |=> $stable(mode_r)); // R5
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (rst) rd_status && !click_evt && !mov_valid |=> !st_click && !st_mov && !st_rderr); // R7
  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (rst) rd_status && !click_evt && !mov_valid |=> irq_n); // R8
  AST_NAV_CLEAR: assert property (@(posedge clk) disable iff (rst) rd_nav && !mov_valid |=> nav_x == 8'h00 && nav_y == 8'h00); // R9
  AST_NAV_CLICK_KEPT: assert property (@(posedge clk) disable iff (rst) n_click && !rd_nav |=> n_click); // R10
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst) !sel |=> $stable(bit_cnt)); // R13
endmodule

// File: tb/slow_spi_ctrl_regs_bench.sv
module slow_spi_ctrl_regs_bench;
  logic clk = 0, rst = 1, sck = 1, ss_n = 1, mosi = 0;
  logic click_evt = 0, mov_valid = 0;
  logic [7:0] mov_x_abs = 0, mov_y_abs = 0;
  logic mov_x_neg = 0, mov_y_neg = 0, mov_x_ovf = 0, mov_y_ovf = 0;
  logic miso, miso_oe, irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  slow_spi_ctrl_regs u_slow_spi_ctrl_regs (
    .clk(clk), .rst(rst), .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso),
    .miso_oe(miso_oe), .irq_n(irq_n), .click_evt(click_evt), .mov_valid(mov_valid),
    .mov_x_abs(mov_x_abs), .mov_y_abs(mov_y_abs), .mov_x_neg(mov_x_neg),
    .mov_y_neg(mov_y_neg), .mov_x_ovf(mov_x_ovf), .mov_y_ovf(mov_y_ovf));

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      sck = 0; mosi = d[i];
      wclk(6);
      r[i] = miso;
      sck = 1;
      wclk(6);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [6:0] v);
    logic [7:0] r;
    ss_n = 0; wclk(4);
    xfer({2'b10, a, 2'b00}, r);
    xfer({1'b0, v}, r);
    wclk(4); ss_n = 1; wclk(6);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] r);
    logic [7:0] t;
    ss_n = 0; wclk(4);
    xfer({2'b11, a, 2'b00}, t);
    xfer(8'h00, r);
    wclk(4); ss_n = 1; wclk(6);
  endtask

  task automatic rd_nav(output logic [7:0] f, output logic [7:0] x, output logic [7:0] y, output logic [7:0] z);
    logic [7:0] t;
    ss_n = 0; wclk(4);
    xfer(8'hE0, t);
    xfer(8'h00, f); xfer(8'h00, x); xfer(8'h00, y); xfer(8'h00, z);
    wclk(4); ss_n = 1; wclk(6);
  endtask

  task automatic pulse_click();
    click_evt = 1; wclk(1); click_evt = 0; wclk(2);
  endtask

  task automatic pulse_mov(input logic [7:0] x, input logic [7:0] y, input logic [3:0] fl);
    mov_x_abs = x; mov_y_abs = y;
    {mov_y_ovf, mov_x_ovf, mov_y_neg, mov_x_neg} = fl;
    mov_valid = 1; wclk(1); mov_valid = 0; wclk(2);
  endtask

  task automatic do_reset();
    rst = 1; wclk(3); rst = 0; wclk(3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    finish_run();
  end

  initial begin
    logic [7:0] r, f, x, y, z;
    logic [6:0] v;
    logic exp_hit;
    do_reset();

    check("R4 irq idle", {7'd0, irq_n}, 8'h01);
    rd(4'd0, r); check("R4 status", r, 8'h00);
    rd(4'd1, r); check("R4 mode", r, 8'h04);
    rd(4'd2, r); check("R4 enable", r, 8'h00);
    rd(4'd3, r); check("R4 heat", r, 8'h00);
    rd(4'd4, r); check("R4 navset", r, 8'h20);
    rd(4'd5, r); check("R4 clkset", r, 8'h2D);
    rd(4'd6, r); check("R4 movthr", r, 8'h00);

    // R1 R2 R3: write then read every writable register across a value sweep
    for (int a = 2; a <= 6; a++)
      for (int k = 0; k < 128; k += 9) begin
        v = 7'(k ^ (a * 37));
        wr(4'(a), v);
        rd(4'(a), r);
        check("R3 rw sweep", r, {1'b0, v});
      end
    wr(4'd2, 7'h00);
    wr(4'd6, 7'h00);

    // R6 all mode codes
    for (int c = 0; c < 16; c++) begin
      wr(4'd1, 7'h04);
      v = {4'(c), 3'b101};
      wr(4'd1, v);
      rd(4'd1, r);
      check("R6 mode code", r, (c[3] && (c[2] || c[1])) ? 8'h04 : {1'b0, v});
    end

    // R5 read-only and reserved writes ignored
    wr(4'd0, 7'h7F); rd(4'd0, r); check("R5 status write", r, 8'h00);
    wr(4'd8, 7'h7F); rd_nav(f, x, y, z);
    check("R5 nav write flags", f, 8'h08); check("R5 nav write x", x, 8'h00);
    wr(4'd7, 7'h7F); wr(4'd15, 7'h7F); rd(4'd0, r); check("R5 reserved write", r, 8'h00);

    // R12 reserved read
    rd(4'd7, r); check("R12 reserved data", r, 8'h00);
    rd(4'd0, r); check("R12 rderr bit", r, 8'h08);
    rd(4'd0, r); check("R7 cleared after read", r, 8'h00);

    // R8 interrupt gating
    pulse_click(); check("R8 click disabled", {7'd0, irq_n}, 8'h01);
    rd(4'd0, r); check("R7 click bit", r, 8'h80);
    wr(4'd2, 7'h40); pulse_click(); check("R8 click irq", {7'd0, irq_n}, 8'h00);
    rd(4'd0, r); check("R7 status click", r, 8'h80); check("R8 release", {7'd0, irq_n}, 8'h01);
    wr(4'd2, 7'h04); rd(4'd9, r); check("R8 rderr irq", {7'd0, irq_n}, 8'h00);
    rd(4'd0, r); check("R8 rderr release", {7'd0, irq_n}, 8'h01);
    wr(4'd2, 7'h20); pulse_mov(8'd5, 8'd0, 4'h0); check("R8 mov irq", {7'd0, irq_n}, 8'h00);
    rd(4'd0, r); check("R7 mov bit", r, 8'h40);
    wr(4'd2, 7'h00);

    // R11 threshold sweep, movement must exceed twice the threshold
    for (int t = 0; t < 5; t++)
      for (int s = 0; s < 6; s++) begin
        int th, mv;
        th = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 9 : (t == 3) ? 63 : 127;
        mv = 2 * th + s - 2;
        if (mv < 0) mv = 0;
        if (mv > 255) mv = 255;
        wr(4'd6, 7'(th));
        rd(4'd0, r);
        if (s[0]) pulse_mov(8'(mv), 8'd0, 4'h0); else pulse_mov(8'd0, 8'(mv), 4'h0);
        exp_hit = (mv > 2 * th);
        rd(4'd0, r);
        check("R11 threshold", r, exp_hit ? 8'h40 : 8'h00);
      end
    wr(4'd6, 7'h00);
    rd_nav(f, x, y, z);

    // R9 R14 navigation burst and clear
    pulse_click();
    pulse_mov(8'h12, 8'h34, 4'b0001);
    rd_nav(f, x, y, z);
    check("R9 flags", f, 8'h1A); check("R9 x", x, 8'h12); check("R9 y", y, 8'h34);
    check("R14 trailing", z, 8'h00);
    rd_nav(f, x, y, z);
    check("R9 flags cleared", f, 8'h08); check("R9 x cleared", x, 8'h00); check("R9 y cleared", y, 8'h00);
    pulse_mov(8'hFF, 8'h01, 4'b1110);
    rd_nav(f, x, y, z);
    check("R9 ovf sign", f, 8'hE8); check("R9 x max", x, 8'hFF);
    rd(4'd0, r);

    // R10 status read keeps nav click bit
    pulse_click();
    rd(4'd0, r); check("R10 status click", r, 8'h80);
    rd_nav(f, x, y, z); check("R10 nav click kept", f, 8'h0A);

    // R14 dummy word after single read
    ss_n = 0; wclk(4);
    xfer(8'hC4, r); xfer(8'h00, r); check("R14 first", r, 8'h04);
    xfer(8'h00, r); check("R14 second", r, 8'h00);
    wclk(4); ss_n = 1; wclk(6);

    // R13 partial transfer leaves framing shifted until reset
    do_reset();
    ss_n = 0; wclk(4);
    for (int i = 0; i < 3; i++) begin
      sck = 0; mosi = 0; wclk(6); sck = 1; wclk(6);
    end
    ss_n = 1; wclk(6);
    wr(4'd2, 7'h40);
    pulse_click();
    check("R13 shifted framing", {7'd0, irq_n}, 8'h01);
    do_reset();
    wr(4'd2, 7'h40);
    pulse_click();
    check("R13 realigned by rst", {7'd0, irq_n}, 8'h00);

    finish_run();
  end
endmodule